// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

The adapter sits between a bus master and a 512-byte space of peripheral registers. Every aligned 4-byte group of that space has its own native register width: one byte, one halfword, one word, or none at all. The width comes from a parameter table indexed by address bits [8:2]. The master may issue byte, halfword or word accesses to any location. The adapter turns each access into the native-width operations the register file expects.

An access narrower than the register is served from the containing register. A read fetches the container and picks out the addressed bytes. A write fetches the container, replaces the addressed bytes and writes the whole container back. An access wider than the register is cut into native-width pieces at ascending addresses. The pieces are joined big-endian, so the lowest address is the most significant. The adapter does not forward an erroneous access. It reports the access with an error flag and all-zero read data.

Both edges of the adapter use valid/ready handshakes. A request is taken only while the adapter is idle, and one access is handled at a time. Once the response is raised, it holds its data and flag until the master takes it. On the register side, the adapter keeps each native request stable until the register file raises ready. In the cycle of that handshake the register file returns read data right-justified on `reg_rdata`. All data is right-justified on every port: a byte is in bits [7:0] and a halfword in bits [15:0].

Top module: `regw_adapter`

## Requirements
- R1: An access whose address is 0x200 or above completes with `rsp_err`=1 and `rsp_rdata`=0, and no native operation is issued for it.
- R2: The native width of a group is a 2-bit code taken from `WIDTH_MAP` at address bits [8:2]: 0 means no register, 1 byte, 2 halfword, 3 word. An access to a code-0 group completes like R1. The default table gives these widths:
  - groups 0–15 are bytes;
  - groups 16–47 are words when the group number is divisible by 3, and halfwords otherwise;
  - groups 48–63 have no register;
  - groups 64–127 are halfwords when the group number is even, and bytes when it is odd.
- R3: `req_size` is encoded 0 for byte, 1 for halfword and 2 for word. Size code 3 is an error, and so is an address that is not aligned to the access size. Either case completes like R1.
- R4: An access whose size equals the native width is carried out as exactly one native operation at the same address.
- R5: A read narrower than the register issues one native read of the whole aligned container and returns the addressed bytes. The container is big-endian: its lowest address holds its most significant byte.
- R6: A write narrower than the register issues a native read of the container and then a native write of it. In that write only the addressed bytes carry new data; all other bytes keep the value just read.
- R7: An access wider than the register is split into (access bytes / native bytes) native operations at ascending addresses, one native width apart. The first piece is the most significant part of the data.
- R8: Every native operation has the native width of its group and is aligned to it. The adapter holds `reg_valid` and all the native request fields stable until `reg_ready`.
- R9: `req_ready` is high only when no access is in progress. The response is raised only after the last native operation of the access. The response keeps its data and flag until `rsp_ready`.
- R10: After reset, `req_ready` is 1 and both `rsp_valid` and `reg_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Master presents an access |
| req_ready | output | 1 | Adapter is idle and takes the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Access complete |
| rsp_ready | input | 1 | Master takes the response |
| rsp_err | output | 1 | Access was rejected |
| rsp_rdata | output | 32 | Read data, right-justified; zero for writes and errors |
| reg_valid | output | 1 | Native operation requested |
| reg_ready | input | 1 | Register file accepts the operation |
| reg_write | output | 1 | Native operation is a write |
| reg_size | output | 2 | Native width, same encoding as `req_size` |
| reg_addr | output | 9 | Native byte address, aligned to `reg_size` |
| reg_wdata | output | 32 | Native write data, right-justified |
| reg_rdata | input | 32 | Native read data, valid at the handshake |

## Verification
The embedded assertions check the handshake rules on every cycle:
- A stalled native request stays stable.
- A pending response holds its data and flag.
- The adapter never takes a request while busy.
- An error response never carries data and never causes a native operation.

The byte-level meaning of each conversion can only be shown by the bench's scenarios. These cover big-endian lane placement, the merge in a read-modify-write, and the order and number of split pieces. The bench compares results against a flat big-endian byte model, counts the native operations and checks their width and alignment.

// File: rtl/regw_pkg.sv
package regw_pkg;

  localparam int SPACE_BYTES = 512;
  localparam int GROUPS      = SPACE_BYTES / 4;
  localparam int LOC_W       = $clog2(SPACE_BYTES);

  // access / native size codes
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  // per-group native width codes held in the width map
  typedef enum logic [1:0] {
    W_NONE = 2'd0,
    W_BYTE = 2'd1,
    W_HALF = 2'd2,
    W_WORD = 2'd3
  } wcode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OP   = 2'd1,
    ST_WB   = 2'd2,
    ST_RSP  = 2'd3
  } st_e;

  // default width map, computed rather than listed
  function automatic logic [2*GROUPS-1:0] default_map();
    logic [2*GROUPS-1:0] m;
    logic [1:0]          c;
    m = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (g < 16)      c = W_BYTE;
      else if (g < 48) c = (g % 3 == 0) ? W_WORD : W_HALF;
      else if (g < 64) c = W_NONE;
      else             c = (g % 2 == 0) ? W_HALF : W_BYTE;
      m[2*g +: 2] = c;
    end
    return m;
  endfunction

endpackage

// File: rtl/regw_width_lut.sv
module regw_width_lut
  import regw_pkg::*;
#(
  parameter int                  ADDR_W = 12,
  parameter logic [2*GROUPS-1:0] MAP    = default_map()
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [1:0]        nsize,
  output logic              err
);

  localparam int GRP_W = LOC_W - 2;

  logic [GRP_W-1:0] grp;
  logic [1:0]       code;
  logic             out_range;
  logic             misal;

  assign grp  = addr[LOC_W-1:2];
  assign code = MAP[{grp, 1'b0} +: 2];

  generate
    if (ADDR_W > LOC_W) begin : g_range
      assign out_range = |addr[ADDR_W-1:LOC_W];
    end else begin : g_norange
      assign out_range = 1'b0;
    end
  endgenerate

  always_comb begin
    case (size)
      SZ_BYTE: misal = 1'b0;
      SZ_HALF: misal = addr[0];
      SZ_WORD: misal = |addr[1:0];
      default: misal = 1'b1;
    endcase
  end

  assign err   = out_range | misal | (code == W_NONE);
  assign nsize = code - 2'd1;

endmodule

// File: rtl/regw_lanes.sv
module regw_lanes
  import regw_pkg::*;
(
  input  logic [1:0]  nsize,
  input  logic [1:0]  asize,
  input  logic [1:0]  off,
  input  logic [1:0]  idx,
  input  logic [31:0] hold,
  input  logic [31:0] wdata,
  output logic [31:0] extract,
  output logic [31:0] merged,
  output logic [31:0] piece,
  output logic [31:0] native
);

  function automatic logic [31:0] lane_mask(input logic [1:0] c);
    case (c)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  logic [2:0]  nb, sb, sh_b, pc_b;
  logic [1:0]  offn;
  logic [31:0] smask, nmask;

  always_comb begin
    nb    = 3'd1 << nsize;
    sb    = 3'd1 << asize;
    offn  = off & (nb[1:0] - 2'd1);
    // byte distance of the addressed field from the container's low end
    sh_b  = nb - {1'b0, offn} - sb;
    // byte distance of piece idx from the low end of the request data
    pc_b  = sb - (({1'b0, idx} + 3'd1) << nsize);
    smask = lane_mask(asize);
    nmask = lane_mask(nsize);
    extract = (hold >> {sh_b, 3'b000}) & smask;
    merged  = (hold & ~(smask << {sh_b, 3'b000}))
            | ((wdata & smask) << {sh_b, 3'b000});
    piece   = (wdata >> {pc_b, 3'b000}) & nmask;
    native  = hold & nmask;
  end

endmodule

// File: rtl/regw_seq.sv
module regw_seq
  import regw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [LOC_W-1:0] req_loc,
  input  logic [31:0]      req_wdata,
  input  logic             lut_err,
  input  logic [1:0]       lut_nsize,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_err,
  output logic [31:0]      rsp_rdata,
  output logic             reg_valid,
  input  logic             reg_ready,
  output logic             reg_write,
  output logic [1:0]       reg_size,
  output logic [LOC_W-1:0] reg_addr,
  output logic [31:0]      reg_wdata,
  input  logic [31:0]      reg_rdata,
  output logic [1:0]       ln_nsize,
  output logic [1:0]       ln_asize,
  output logic [1:0]       ln_off,
  output logic [1:0]       ln_idx,
  output logic [31:0]      ln_hold,
  output logic [31:0]      ln_wdata,
  input  logic [31:0]      ln_extract,
  input  logic [31:0]      ln_merged,
  input  logic [31:0]      ln_piece,
  input  logic [31:0]      ln_native
);

  st_e              st;
  logic [LOC_W-1:0] a_loc;
  logic [1:0]       a_size, n_size;
  logic             a_we, a_rmw, a_err;
  logic [31:0]      a_wdata, acc;
  logic [1:0]       idx, last_idx;
  logic [LOC_W-1:0] align_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      a_loc    <= '0;
      a_size   <= '0;
      n_size   <= '0;
      a_we     <= 1'b0;
      a_rmw    <= 1'b0;
      a_err    <= 1'b0;
      a_wdata  <= '0;
      acc      <= '0;
      idx      <= '0;
      last_idx <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          a_loc   <= req_loc;
          a_size  <= req_size;
          a_we    <= req_write;
          a_wdata <= req_wdata;
          n_size  <= lut_nsize;
          idx     <= '0;
          acc     <= '0;
          a_err   <= lut_err;
          a_rmw   <= req_write && (req_size < lut_nsize);
          last_idx <= (req_size > lut_nsize)
                      ? ((2'd1 << (req_size - lut_nsize)) - 2'd1) : 2'd0;
          st      <= lut_err ? ST_RSP : ST_OP;
        end
        ST_OP: if (reg_ready) begin
          if (a_rmw) begin
            acc <= reg_rdata;
            st  <= ST_WB;
          end else begin
            if (!a_we) begin
              if (a_size < n_size)       acc <= ln_extract;
              else if (a_size == n_size) acc <= ln_native;
              else if (n_size == SZ_BYTE) acc <= {acc[23:0], ln_native[7:0]};
              else                        acc <= {acc[15:0], ln_native[15:0]};
            end
            if (idx == last_idx) st <= ST_RSP;
            else                 idx <= idx + 2'd1;
          end
        end
        ST_WB: if (reg_ready) begin
          acc <= '0;
          st  <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (n_size)
      SZ_BYTE: align_m = '0;
      SZ_HALF: align_m = LOC_W'(1);
      default: align_m = LOC_W'(3);
    endcase
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RSP);
  assign rsp_err   = a_err;
  assign rsp_rdata = acc;

  assign reg_valid = (st == ST_OP) || (st == ST_WB);
  assign reg_write = (st == ST_WB) || ((st == ST_OP) && a_we && !a_rmw);
  assign reg_size  = n_size;
  assign reg_addr  = (a_loc & ~align_m) + ({{(LOC_W-2){1'b0}}, idx} << n_size);
  assign reg_wdata = (st == ST_WB) ? ln_merged : ln_piece;

  assign ln_nsize = n_size;
  assign ln_asize = a_size;
  assign ln_off   = a_loc[1:0];
  assign ln_idx   = idx;
  assign ln_hold  = (st == ST_WB) ? acc : reg_rdata;
  assign ln_wdata = a_wdata;

  AST_NATIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_ready |=> reg_valid && $stable(reg_addr) && $stable(reg_size)
      && $stable(reg_write) && $stable(reg_wdata)); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)); // R9

  AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !reg_valid && !rsp_valid); // R9

  AST_ERR_NO_NATIVE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && lut_err |=> !reg_valid && rsp_valid && rsp_err); // R1

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == 32'd0); // R2

  AST_NATIVE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> reg_size != SZ_BAD); // R8

endmodule

// File: rtl/regw_adapter.sv
module regw_adapter
  import regw_pkg::*;
#(
  parameter int                  ADDR_W    = 12,
  parameter logic [2*GROUPS-1:0] WIDTH_MAP = default_map()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              reg_valid,
  input  logic              reg_ready,
  output logic              reg_write,
  output logic [1:0]        reg_size,
  output logic [LOC_W-1:0]  reg_addr,
  output logic [31:0]       reg_wdata,
  input  logic [31:0]       reg_rdata
);

  logic [1:0]  lut_nsize;
  logic        lut_err;
  logic [1:0]  ln_nsize, ln_asize, ln_off, ln_idx;
  logic [31:0] ln_hold, ln_wdata, ln_extract, ln_merged, ln_piece, ln_native;

  regw_width_lut #(.ADDR_W(ADDR_W), .MAP(WIDTH_MAP)) u_lut (
    .addr  (req_addr),
    .size  (req_size),
    .nsize (lut_nsize),
    .err   (lut_err)
  );

  regw_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_loc    (req_addr[LOC_W-1:0]),
    .req_wdata  (req_wdata),
    .lut_err    (lut_err),
    .lut_nsize  (lut_nsize),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .reg_valid  (reg_valid),
    .reg_ready  (reg_ready),
    .reg_write  (reg_write),
    .reg_size   (reg_size),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ln_nsize   (ln_nsize),
    .ln_asize   (ln_asize),
    .ln_off     (ln_off),
    .ln_idx     (ln_idx),
    .ln_hold    (ln_hold),
    .ln_wdata   (ln_wdata),
    .ln_extract (ln_extract),
    .ln_merged  (ln_merged),
    .ln_piece   (ln_piece),
    .ln_native  (ln_native)
  );

  regw_lanes u_lanes (
    .nsize   (ln_nsize),
    .asize   (ln_asize),
    .off     (ln_off),
    .idx     (ln_idx),
    .hold    (ln_hold),
    .wdata   (ln_wdata),
    .extract (ln_extract),
    .merged  (ln_merged),
    .piece   (ln_piece),
    .native  (ln_native)
  );

endmodule

// File: tb/regw_adapter_tb.sv
module regw_adapter_tb;
  import regw_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]        req_size = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              req_ready, rsp_valid, rsp_err, reg_valid, reg_write;
  logic              rsp_ready, reg_ready;
  logic [31:0]       rsp_rdata, reg_wdata, reg_rdata;
  logic [1:0]        reg_size;
  logic [LOC_W-1:0]  reg_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  regw_adapter #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
    .reg_size(reg_size), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // back-pressure patterns
  logic [7:0] cyc = '0;
  logic       stall_en = 1'b0;
  always @(posedge clk) cyc <= cyc + 8'd1;
  assign reg_ready = stall_en ? (cyc[1:0] != 2'b11) : 1'b1;
  assign rsp_ready = stall_en ? (cyc % 5 != 2) : 1'b1;

  // model register file and expected byte image
  logic [7:0] model_mem [SPACE_BYTES];
  logic [7:0] exp_mem   [SPACE_BYTES];

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < 4; i++)
      if (i < (1 << reg_size)) reg_rdata = (reg_rdata << 8) | {24'd0, model_mem[reg_addr + LOC_W'(i)]};
  end

  always @(posedge clk) begin
    if (reg_valid && reg_ready && reg_write) begin
      for (int i = 0; i < 4; i++)
        if (i < (1 << reg_size))
          model_mem[reg_addr + LOC_W'(i)] <= reg_wdata[8*((1 << reg_size) - 1 - i) +: 8];
    end
  end

  typedef struct {
    logic        err;
    logic [31:0] rdata;
    int          nops;
    logic [1:0]  nsz;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  function automatic int wcode(input int a);
    int g;
    g = a / 4;
    if (g < 16)      return 1;
    else if (g < 48) return (g % 3 == 0) ? 3 : 2;
    else if (g < 64) return 0;
    else             return (g % 2 == 0) ? 2 : 1;
  endfunction

  // monitor: native shape, stall stability, response scoreboard
  int          nat_ops = 0;
  bit          nat_bad = 1'b0;
  bit          prev_stall = 1'b0;
  logic [LOC_W-1:0] p_addr;
  logic [1:0]  p_size;
  logic        p_write;
  logic [31:0] p_wdata;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        if (!reg_valid || reg_addr != p_addr || reg_size != p_size ||
            reg_write != p_write || reg_wdata != p_wdata) nat_bad = 1'b1;
      end
      if (reg_valid) begin
        if (sb_q.size() > 0 && reg_size != sb_q[0].nsz) nat_bad = 1'b1;
        if ((int'(reg_addr) % (1 << reg_size)) != 0) nat_bad = 1'b1;
        if (reg_ready) nat_ops++;
      end
      prev_stall = reg_valid && !reg_ready;
      p_addr = reg_addr; p_size = reg_size; p_write = reg_write; p_wdata = reg_wdata;
      if (rsp_valid && rsp_ready) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R9 unexpected response", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(rsp_err == e.err, {e.tag, " error flag"}, {31'd0, rsp_err}, {31'd0, e.err});
          chk(rsp_rdata == e.rdata, {e.tag, " read data"}, rsp_rdata, e.rdata);
          chk(nat_ops == e.nops, {e.tag, " R9 native operations before response"}, nat_ops, e.nops);
          chk(!nat_bad, "R8 native width, alignment and stability", {31'd0, nat_bad}, 32'd0);
        end
        nat_ops = 0;
        nat_bad = 1'b0;
      end
    end
  end

  // driver: computes the expectation, then presents the access
  task automatic access(input bit we, input logic [1:0] size, input int addr,
                        input logic [31:0] wdata, input string tag);
    exp_t e;
    int   s, n, w;
    s = 1 << size;
    e.tag = tag; e.rdata = '0; e.nops = 0; e.nsz = '0;
    w = (addr < SPACE_BYTES) ? wcode(addr) : 0;
    e.err = (addr >= SPACE_BYTES) || (size == 2'd3) || (addr % s != 0) || (w == 0);
    if (!e.err) begin
      n = 1 << (w - 1);
      e.nsz = 2'(w - 1);
      if (we) begin
        for (int i = 0; i < s; i++) exp_mem[addr + i] = wdata[8*(s-1-i) +: 8];
      end else begin
        for (int i = 0; i < s; i++) e.rdata = (e.rdata << 8) | {24'd0, exp_mem[addr + i]};
      end
      if (s == n)     e.nops = 1;
      else if (s < n) e.nops = we ? 2 : 1;
      else            e.nops = s / n;
    end
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_size = size;
    req_addr = ADDR_W'(addr); req_wdata = wdata;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < SPACE_BYTES; i++) begin
      model_mem[i] = 8'(i * 7 + 3);
      exp_mem[i]   = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 req_ready after reset", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid == 1'b0, "R10 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk(reg_valid == 1'b0, "R10 reg_valid after reset", {31'd0, reg_valid}, 32'd0);

    // matching widths
    access(1'b0, 2'd0, 'h005, '0, "R4");
    access(1'b1, 2'd0, 'h005, 32'h5A, "R4");
    access(1'b0, 2'd0, 'h005, '0, "R4");
    access(1'b0, 2'd2, 'h048, '0, "R4");
    access(1'b0, 2'd1, 'h100, '0, "R4");

    stall_en = 1'b1;
    // narrow reads
    access(1'b0, 2'd0, 'h040, '0, "R5");
    access(1'b0, 2'd0, 'h041, '0, "R5");
    access(1'b0, 2'd0, 'h04A, '0, "R5");
    access(1'b0, 2'd1, 'h04A, '0, "R5");
    access(1'b0, 2'd1, 'h048, '0, "R5");
    // narrow writes (read-modify-write)
    access(1'b1, 2'd0, 'h041, 32'hA5, "R6");
    access(1'b0, 2'd1, 'h040, '0, "R6");
    access(1'b1, 2'd0, 'h04A, 32'hC3, "R6");
    access(1'b1, 2'd1, 'h048, 32'h1234, "R6");
    access(1'b0, 2'd2, 'h048, '0, "R6");
    // wide accesses
    access(1'b0, 2'd1, 'h006, '0, "R7");
    access(1'b1, 2'd1, 'h006, 32'hBEEF, "R7");
    access(1'b0, 2'd2, 'h008, '0, "R7");
    access(1'b1, 2'd2, 'h00C, 32'hDEADBEEF, "R7");
    access(1'b0, 2'd2, 'h00C, '0, "R7");
    access(1'b0, 2'd2, 'h100, '0, "R7");
    access(1'b1, 2'd2, 'h044, 32'hCAFE0123, "R7");
    access(1'b0, 2'd2, 'h044, '0, "R7");
    access(1'b0, 2'd2, 'h1FC, '0, "R7");
    // errors
    access(1'b0, 2'd0, 'h200, '0, "R1");
    access(1'b1, 2'd2, 'h3F0, 32'hFFFFFFFF, "R1");
    access(1'b0, 2'd0, 'h0C0, '0, "R2");
    access(1'b1, 2'd1, 'h0C2, 32'h7777, "R2");
    access(1'b0, 2'd1, 'h041, '0, "R3");
    access(1'b0, 2'd3, 'h040, '0, "R3");
    access(1'b0, 2'd2, 'h006, '0, "R3");
    // state unchanged behind the rejected accesses
    access(1'b0, 2'd2, 'h0C4, '0, "R2");
    access(1'b0, 2'd2, 'h040, '0, "R6");

    while (sb_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule